// File: doc/BRIEF.md
# Fuzzy Inference Engine

This block evaluates a Mamdani-style fuzzy rule base whose consequents are crisp singletons. A host fills eight 8-bit input variables through a load port, then issues a start command that names the register-file destination for the result. The engine then steps through a byte-coded rule program held in a 1 KB external memory. The program starts at address 0 and is read through a synchronous port with one cycle of latency.

Each rule's antecedent is written in postfix order. A membership opcode computes the activation of one input against a trapezoid and pushes it onto an operand stack. The AND, OR and NOT opcodes combine the stacked values, so nested brackets of any depth that fits the stack reduce to stack order. A rule opcode pops the truth value and adds it, weighted by its singleton, to two running sums. The end opcode divides the weighted sum by the sum of weights on a shared sequential divider. It writes the 8-bit result to the chosen register-file address and then pulses done.

Top module: `fuzzy_infer_engine`

## Requirements
- R1: There are eight 8-bit input registers. A cycle with `loadEn` high writes `loadData` into the register selected by `loadIdx`. The membership opcode 0x10+i (i = 0..7) reads register i.
- R2: `start` while idle latches `destAddr` and begins the program at address 0. `busy` is high from the next cycle. A `start` while busy is ignored and is not queued.
- R3: Opcodes are 0x10..0x17 (membership, followed by four breakpoint bytes a, b, c, d), 0x20 AND, 0x21 OR, 0x22 NOT, 0x30 RULE (followed by one singleton byte) and 0xFF END. Any other byte is skipped as a one-byte no-op.
- R4: For a ≤ b ≤ c ≤ d and input x, the activation is 0 when x < a or x > d, and 255 when b ≤ x ≤ c. It is floor((x−a)·255/(b−a)) when a ≤ x < b, and floor((d−x)·255/(d−c)) when c < x ≤ d.
- R5: AND replaces the two top stack entries with their minimum. OR replaces them with their maximum.
- R6: NOT replaces the top entry v with 255 − v.
- R7: Nested groupings are evaluated in postfix order on an operand stack that holds at least 8 entries.
- R8: RULE pops the top entry w, adds w to the weight sum, and adds w times the singleton byte to the weighted sum. Any number of rules may appear in one program.
- R9: END yields floor(weighted sum / weight sum). When the weight sum is 0, it yields 0.
- R10: Each inference raises `rfWrEn` for exactly one cycle, with `rfWrAddr` equal to the latched destination (0..127) and `rfWrData` equal to the result.
- R11: `done` is high for exactly one cycle, the cycle after the write. `busy` falls in the cycle after `done`.
- R12: After reset, `busy`, `done` and `rfWrEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Write strobe for an input register |
| loadIdx | input | 3 | Input register index |
| loadData | input | 8 | Value to load |
| start | input | 1 | Begin an inference (ignored while busy) |
| destAddr | input | 7 | Register-file destination for the result |
| memRdAddr | output | 10 | Program memory read address |
| memRdData | input | 8 | Program memory data, one cycle after the address |
| rfWrEn | output | 1 | Result write strobe |
| rfWrAddr | output | 7 | Result write address |
| rfWrData | output | 8 | Result value |
| busy | output | 1 | Inference in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the rule program is well formed. Every membership opcode has ordered breakpoints, no operator pops more entries than are stacked, the stack never exceeds its depth, and every program reaches END. The bench builds only such programs: trapezoids with ordered corners, postfix expressions with balanced operands, and a stack that peaks at exactly the design depth. The assertions also assume that `loadEn` is quiet during an inference, and the stimulus loads inputs only while the engine is idle. Each result is compared with an arithmetic model of the activation, min/max/complement and weighted-average formulas.

// File: rtl/fie_pkg.sv
package fie_pkg;

  localparam logic [7:0] OP_MBF      = 8'h10;
  localparam logic [7:0] OP_MBF_MASK = 8'hF8;
  localparam logic [7:0] OP_AND      = 8'h20;
  localparam logic [7:0] OP_OR       = 8'h21;
  localparam logic [7:0] OP_NOT      = 8'h22;
  localparam logic [7:0] OP_RULE     = 8'h30;
  localparam logic [7:0] OP_END      = 8'hFF;

  // Strobes from the sequencer to the datapath, one cycle each.
  typedef struct packed {
    logic clrRun;
    logic pcInc;
    logic latchOp;
    logic latchBp;
    logic pushAlpha;
    logic pushDiv;
    logic opAnd;
    logic opOr;
    logic opNot;
    logic ruleAcc;
    logic divGo;
    logic divDefuzz;
    logic wrBack;
  } fie_strobe_t;

endpackage

// File: rtl/fie_div.sv
module fie_div #(
  parameter int W  = 26,
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          go,
  input  logic [W-1:0]  num,
  input  logic [W-1:0]  den,
  output logic [QW-1:0] quo,
  output logic          done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  remR;
  logic [W-1:0]  quoR;
  logic [W-1:0]  denR;
  logic [CW-1:0] cnt;
  logic [W:0]    trial;
  logic [W-1:0]  diff;
  logic          fits;

  assign trial = {remR, quoR[W-1]};
  assign fits  = trial >= {1'b0, denR};
  assign diff  = trial[W-1:0] - denR;
  assign quo   = quoR[QW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR <= '0;
      quoR <= '0;
      denR <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (go) begin
      remR <= '0;
      quoR <= num;
      denR <= den;
      cnt  <= CW'(W);
      done <= 1'b0;
    end else if (cnt != '0) begin
      remR <= fits ? diff : trial[W-1:0];
      quoR <= {quoR[W-2:0], fits};
      cnt  <= cnt - CW'(1);
      done <= (cnt == CW'(1));
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/fie_dp.sv
module fie_dp import fie_pkg::*; #(
  parameter int IN_NUM      = 8,
  parameter int DATA_W      = 8,
  parameter int PC_W        = 10,
  parameter int DEST_W      = 7,
  parameter int STACK_DEPTH = 8,
  parameter int ACC_W       = 26,
  localparam int IDX_W      = $clog2(IN_NUM)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fie_strobe_t       stb,
  input  logic              loadEn,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic [DATA_W-1:0] loadData,
  input  logic [DEST_W-1:0] destAddr,
  output logic [PC_W-1:0]   memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DEST_W-1:0] rfWrAddr,
  output logic [DATA_W-1:0] rfWrData,
  output logic              alphaSlope,
  output logic              sumWZero,
  output logic              divDone
);
  localparam int SP_W = $clog2(STACK_DEPTH + 1);
  localparam int SI_W = $clog2(STACK_DEPTH);
  localparam int BP_W = 4 * DATA_W;
  localparam logic [DATA_W-1:0] MAXV = '1;

  // input variable bank
  logic [DATA_W-1:0] inReg [IN_NUM];
  for (genvar g = 0; g < IN_NUM; g++) begin : gInReg
    logic [DATA_W-1:0] val;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) val <= '0;
      else if (loadEn && loadIdx == IDX_W'(g)) val <= loadData;
    end
    assign inReg[g] = val;
  end

  // program counter, opcode operand, breakpoints, destination
  logic [PC_W-1:0]   pc;
  logic [IDX_W-1:0]  opIdx;
  logic [BP_W-1:0]   bpSh;
  logic [DEST_W-1:0] destReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc      <= '0;
      opIdx   <= '0;
      bpSh    <= '0;
      destReg <= '0;
    end else begin
      if (stb.clrRun) begin
        pc      <= '0;
        destReg <= destAddr;
      end else if (stb.pcInc) begin
        pc <= pc + PC_W'(1);
      end
      if (stb.latchOp) opIdx <= memRdData[IDX_W-1:0];
      if (stb.latchBp) bpSh  <= {bpSh[BP_W-DATA_W-1:0], memRdData};
    end
  end

  assign memRdAddr = pc;
  assign rfWrAddr  = destReg;

  // trapezoid classification
  logic [DATA_W-1:0] xVal, bpA, bpB, bpC, bpD, slopeRise, slopeSpan;
  logic              isZero, isFull, rising;
  logic [DATA_W-1:0] constAlpha;
  logic [ACC_W-1:0]  alphaNum, alphaDen;

  assign xVal   = inReg[opIdx];
  assign bpA    = bpSh[BP_W-1 -: DATA_W];
  assign bpB    = bpSh[BP_W-DATA_W-1 -: DATA_W];
  assign bpC    = bpSh[2*DATA_W-1 -: DATA_W];
  assign bpD    = bpSh[DATA_W-1:0];
  assign isZero = (xVal < bpA) || (xVal > bpD);
  assign isFull = (xVal >= bpB) && (xVal <= bpC);
  assign rising = xVal < bpB;
  assign alphaSlope = !isZero && !isFull;
  assign constAlpha = isFull ? MAXV : '0;
  assign slopeRise  = rising ? (xVal - bpA) : (bpD - xVal);
  assign slopeSpan  = rising ? (bpB - bpA) : (bpD - bpC);
  assign alphaNum   = ACC_W'(slopeRise) * ACC_W'(MAXV);
  assign alphaDen   = ACC_W'(slopeSpan);

  // operand stack
  logic [DATA_W-1:0] stk [STACK_DEPTH];
  logic [SP_W-1:0]   sp, spNext;
  logic [SI_W-1:0]   topIdx, nxtIdx, pushIdx, stkWIdx;
  logic [DATA_W-1:0] topVal, nxtVal, stkWData, divQuo;
  logic              stkWe;

  assign topIdx  = SI_W'(sp - SP_W'(1));
  assign nxtIdx  = SI_W'(sp - SP_W'(2));
  assign pushIdx = SI_W'(sp);
  assign topVal  = stk[topIdx];
  assign nxtVal  = stk[nxtIdx];

  always_comb begin
    stkWe    = 1'b0;
    stkWIdx  = pushIdx;
    stkWData = constAlpha;
    spNext   = sp;
    if (stb.clrRun) begin
      spNext = '0;
    end else if (stb.pushAlpha) begin
      stkWe  = 1'b1;
      spNext = sp + SP_W'(1);
    end else if (stb.pushDiv) begin
      stkWe    = 1'b1;
      stkWData = divQuo;
      spNext   = sp + SP_W'(1);
    end else if (stb.opAnd || stb.opOr) begin
      stkWe   = 1'b1;
      stkWIdx = nxtIdx;
      if (stb.opAnd) stkWData = (nxtVal < topVal) ? nxtVal : topVal;
      else           stkWData = (nxtVal > topVal) ? nxtVal : topVal;
      spNext  = sp - SP_W'(1);
    end else if (stb.opNot) begin
      stkWe    = 1'b1;
      stkWIdx  = topIdx;
      stkWData = MAXV - topVal;
    end else if (stb.ruleAcc) begin
      spNext = sp - SP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sp <= '0;
    else       sp <= spNext;
  end

  always_ff @(posedge clk) begin
    if (stkWe) stk[stkWIdx] <= stkWData;
  end

  // rule accumulation
  logic [ACC_W-1:0] sumW, sumWS;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumW  <= '0;
      sumWS <= '0;
    end else if (stb.clrRun) begin
      sumW  <= '0;
      sumWS <= '0;
    end else if (stb.ruleAcc) begin
      sumW  <= sumW + ACC_W'(topVal);
      sumWS <= sumWS + ACC_W'(topVal) * ACC_W'(memRdData);
    end
  end
  assign sumWZero = (sumW == '0);

  // shared divider: slope activation or final weighted average
  logic [ACC_W-1:0] divNum, divDen;
  assign divNum = stb.divDefuzz ? sumWS : alphaNum;
  assign divDen = stb.divDefuzz ? sumW  : alphaDen;

  fie_div #(.W(ACC_W), .QW(DATA_W)) u_div (
    .clk  (clk),
    .rstN (rstN),
    .go   (stb.divGo),
    .num  (divNum),
    .den  (divDen),
    .quo  (divQuo),
    .done (divDone)
  );

  assign rfWrData = sumWZero ? '0 : divQuo;
endmodule

// File: rtl/fie_ctrl.sv
module fie_ctrl import fie_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int BP_NUM = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              alphaSlope,
  input  logic              sumWZero,
  input  logic              divDone,
  output fie_strobe_t       stb,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = $clog2(BP_NUM);

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DECODE, S_RDBP, S_CAPBP, S_ALPHA, S_ADIV,
    S_RDS, S_CAPS, S_DEF, S_DDIV, S_WRITE, S_DONE
  } state_t;

  state_t          state, stateNext;
  logic [CNT_W-1:0] bpCnt;

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: if (start) begin
        stb.clrRun = 1'b1;
        stateNext  = S_FETCH;
      end
      S_FETCH: begin
        stb.pcInc = 1'b1;
        stateNext = S_DECODE;
      end
      S_DECODE: begin
        stb.latchOp = 1'b1;
        stateNext   = S_FETCH;
        if ((memRdData & OP_MBF_MASK) == OP_MBF) stateNext = S_RDBP;
        else if (memRdData == OP_AND)  stb.opAnd = 1'b1;
        else if (memRdData == OP_OR)   stb.opOr  = 1'b1;
        else if (memRdData == OP_NOT)  stb.opNot = 1'b1;
        else if (memRdData == OP_RULE) stateNext = S_RDS;
        else if (memRdData == OP_END)  stateNext = S_DEF;
      end
      S_RDBP: begin
        stb.pcInc = 1'b1;
        stateNext = S_CAPBP;
      end
      S_CAPBP: begin
        stb.latchBp = 1'b1;
        stateNext   = (bpCnt == CNT_W'(BP_NUM - 1)) ? S_ALPHA : S_RDBP;
      end
      S_ALPHA: begin
        if (alphaSlope) begin
          stb.divGo = 1'b1;
          stateNext = S_ADIV;
        end else begin
          stb.pushAlpha = 1'b1;
          stateNext     = S_FETCH;
        end
      end
      S_ADIV: if (divDone) begin
        stb.pushDiv = 1'b1;
        stateNext   = S_FETCH;
      end
      S_RDS: begin
        stb.pcInc = 1'b1;
        stateNext = S_CAPS;
      end
      S_CAPS: begin
        stb.ruleAcc = 1'b1;
        stateNext   = S_FETCH;
      end
      S_DEF: begin
        if (sumWZero) begin
          stateNext = S_WRITE;
        end else begin
          stb.divGo     = 1'b1;
          stb.divDefuzz = 1'b1;
          stateNext     = S_DDIV;
        end
      end
      S_DDIV: if (divDone) stateNext = S_WRITE;
      S_WRITE: begin
        stb.wrBack = 1'b1;
        stateNext  = S_DONE;
      end
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      bpCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == S_DECODE)     bpCnt <= '0;
      else if (state == S_CAPBP) bpCnt <= bpCnt + CNT_W'(1);
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);
endmodule

// File: rtl/fuzzy_infer_engine.sv
module fuzzy_infer_engine import fie_pkg::*; #(
  parameter int IN_NUM      = 8,
  parameter int DATA_W      = 8,
  parameter int PC_W        = 10,
  parameter int DEST_W      = 7,
  parameter int STACK_DEPTH = 8,
  parameter int ACC_W       = 26,
  localparam int IDX_W      = $clog2(IN_NUM)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic [DATA_W-1:0] loadData,
  input  logic              start,
  input  logic [DEST_W-1:0] destAddr,
  output logic [PC_W-1:0]   memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              rfWrEn,
  output logic [DEST_W-1:0] rfWrAddr,
  output logic [DATA_W-1:0] rfWrData,
  output logic              busy,
  output logic              done
);
  fie_strobe_t stb;
  logic        alphaSlope, sumWZero, divDone;

  fie_ctrl #(.DATA_W(DATA_W), .BP_NUM(4)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .memRdData  (memRdData),
    .alphaSlope (alphaSlope),
    .sumWZero   (sumWZero),
    .divDone    (divDone),
    .stb        (stb),
    .busy       (busy),
    .done       (done)
  );

  fie_dp #(
    .IN_NUM(IN_NUM), .DATA_W(DATA_W), .PC_W(PC_W), .DEST_W(DEST_W),
    .STACK_DEPTH(STACK_DEPTH), .ACC_W(ACC_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .loadEn     (loadEn),
    .loadIdx    (loadIdx),
    .loadData   (loadData),
    .destAddr   (destAddr),
    .memRdAddr  (memRdAddr),
    .memRdData  (memRdData),
    .rfWrAddr   (rfWrAddr),
    .rfWrData   (rfWrData),
    .alphaSlope (alphaSlope),
    .sumWZero   (sumWZero),
    .divDone    (divDone)
  );

  assign rfWrEn = stb.wrBack;
endmodule

// File: rtl/fuzzy_infer_engine_chk.sv
module fuzzy_infer_engine_chk #(
  parameter int DEST_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              rfWrEn,
  input logic [DEST_W-1:0] rfWrAddr
);
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(rfWrEn)); // R11
  AST_WRITE_THEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |=> done); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy)); // R11
  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |=> !rfWrEn); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!rfWrEn && !done)); // R10
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy); // R2
  AST_DEST_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(rfWrAddr)); // R2
endmodule

bind fuzzy_infer_engine fuzzy_infer_engine_chk #(.DEST_W(DEST_W)) u_chk (.*);

// File: tb/fuzzy_infer_engine_tb.sv
module fuzzy_infer_engine_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadEn = 1'b0;
  logic [2:0] loadIdx = '0;
  logic [7:0] loadData = '0;
  logic       start = 1'b0;
  logic [6:0] destAddr = '0;
  logic [9:0] memRdAddr;
  logic [7:0] memRdData = '0;
  logic       rfWrEn;
  logic [6:0] rfWrAddr;
  logic [7:0] rfWrData;
  logic       busy, done;

  int nChecks = 0;
  int nFails  = 0;

  logic [7:0] mem [1024];
  int         inModel [8];
  int         wp;

  int  wrCount, doneCount, lastData, lastAddr;
  logic doneAfterWr, prevWr = 1'b0;

  always #10 clk = ~clk;

  fuzzy_infer_engine u_dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadIdx(loadIdx),
    .loadData(loadData), .start(start), .destAddr(destAddr),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .rfWrEn(rfWrEn),
    .rfWrAddr(rfWrAddr), .rfWrData(rfWrData), .busy(busy), .done(done)
  );

  always @(posedge clk) memRdData <= mem[memRdAddr];

  always @(negedge clk) begin
    if (rfWrEn) begin
      wrCount++;
      lastData = int'(rfWrData);
      lastAddr = int'(rfWrAddr);
    end
    if (done) begin
      doneCount++;
      doneAfterWr = prevWr;
    end
    prevWr = rfWrEn;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic emit(input int b);
    mem[wp] = 8'(b);
    wp++;
  endtask

  task automatic emitMbf(input int idx, input int a, input int b, input int c, input int d);
    emit(16 + idx); emit(a); emit(b); emit(c); emit(d);
  endtask

  task automatic loadInput(input int idx, input int val);
    @(negedge clk);
    loadEn = 1'b1; loadIdx = 3'(idx); loadData = 8'(val);
    @(negedge clk);
    loadEn = 1'b0;
    inModel[idx] = val;
  endtask

  function automatic int refAlpha(input int x, input int a, input int b, input int c, input int d);
    if (x < a || x > d) return 0;
    if (x >= b && x <= c) return 255;
    if (x < b) return ((x - a) * 255) / (b - a);
    return ((d - x) * 255) / (d - c);
  endfunction

  function automatic int refRun();
    int st[16];
    int sp = 0, sw = 0, sws = 0, pc = 0, op, v;
    for (int k = 0; k < 1024; k++) begin
      op = int'(mem[pc]); pc++;
      if (op >= 16 && op <= 23) begin
        v = refAlpha(inModel[op - 16], int'(mem[pc]), int'(mem[pc+1]),
                     int'(mem[pc+2]), int'(mem[pc+3]));
        pc += 4; st[sp] = v; sp++;
      end else if (op == 32) begin
        st[sp-2] = (st[sp-2] < st[sp-1]) ? st[sp-2] : st[sp-1]; sp--;
      end else if (op == 33) begin
        st[sp-2] = (st[sp-2] > st[sp-1]) ? st[sp-2] : st[sp-1]; sp--;
      end else if (op == 34) begin
        st[sp-1] = 255 - st[sp-1];
      end else if (op == 48) begin
        sw += st[sp-1]; sws += st[sp-1] * int'(mem[pc]); pc++; sp--;
      end else if (op == 255) begin
        return (sw == 0) ? 0 : sws / sw;
      end
    end
    return -1;
  endfunction

  task automatic runCheck(input string req, input int dest);
    int exp, guard;
    exp = refRun();
    @(negedge clk);
    wrCount = 0; doneCount = 0; doneAfterWr = 1'b0;
    start = 1'b1; destAddr = 7'(dest);
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (doneCount == 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(req, "result", lastData, exp);
    check("R10", "dest address", lastAddr, dest);
    check("R10", "write count", wrCount, 1);
    check("R11", "done after write", int'(doneAfterWr), 1);
    @(negedge clk);
    check("R11", "busy low after done", int'(busy), 0);
  endtask

  // alpha read back: rule alpha->255 plus rule NOT alpha->0 gives alpha
  task automatic progAlpha(input int idx, input int a, input int b, input int c, input int d);
    wp = 0;
    emitMbf(idx, a, b, c, d); emit(48); emit(255);
    emitMbf(idx, a, b, c, d); emit(34); emit(48); emit(0);
    emit(255);
  endtask

  initial begin
    #4_000_000;
    nFails++;
    $display("FAIL R11 watchdog: actual no completion expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int tr [4][4];
    int guard;
    void'($urandom(7));
    for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
    for (int i = 0; i < 8; i++) inModel[i] = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "busy in reset", int'(busy), 0);
    check("R12", "done in reset", int'(done), 0);
    check("R12", "rfWrEn in reset", int'(rfWrEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R12", "busy after reset", int'(busy), 0);

    // R1: each register read back through ramp 0,255,255,255
    for (int i = 0; i < 8; i++) loadInput(i, 17 + 29 * i);
    for (int i = 0; i < 8; i++) begin
      progAlpha(i, 0, 255, 255, 255);
      runCheck("R1", (i * 37) % 128);
      check("R1", "register value", lastData, 17 + 29 * i);
    end

    // R4: activation sweep over four trapezoids
    tr[0] = '{40, 80, 120, 200};
    tr[1] = '{0, 0, 100, 150};
    tr[2] = '{100, 100, 100, 100};
    tr[3] = '{10, 60, 60, 250};
    for (int t = 0; t < 4; t++) begin
      for (int x = 0; x < 256; x += 5) begin
        loadInput(3, x);
        progAlpha(3, tr[t][0], tr[t][1], tr[t][2], tr[t][3]);
        runCheck("R4", (x + t) % 128);
      end
    end

    // R5 R6 R8: nested expressions, several rules, random inputs
    for (int n = 0; n < 30; n++) begin
      for (int i = 0; i < 5; i++) loadInput(i, int'($urandom_range(255)));
      wp = 0;
      emitMbf(0, 20, 90, 140, 230); emitMbf(1, 0, 60, 60, 180); emit(34); emit(32);
      emitMbf(2, 50, 120, 200, 255); emit(33);
      emitMbf(3, 0, 100, 150, 250); emitMbf(4, 30, 128, 128, 220); emit(33); emit(32);
      emit(48); emit(200);
      emitMbf(0, 0, 50, 100, 200); emitMbf(1, 60, 160, 200, 255); emit(33);
      emit(48); emit(30);
      emitMbf(2, 0, 80, 80, 255); emit(34); emit(48); emit(90);
      emit(255);
      runCheck((n % 2) ? "R5" : "R8", n + 90);
    end

    // R6: complement of a full and empty activation
    loadInput(5, 100);
    wp = 0;
    emitMbf(5, 50, 90, 110, 150); emit(34); emit(48); emit(40);
    emitMbf(5, 200, 210, 220, 230); emit(34); emit(48); emit(240);
    emit(255);
    runCheck("R6", 127);
    check("R6", "NOT of 255 weight 0, NOT of 0 selects singleton", lastData, 240);

    // R7: stack filled to eight entries
    for (int n = 0; n < 10; n++) begin
      for (int i = 0; i < 8; i++) loadInput(i, int'($urandom_range(255)));
      wp = 0;
      for (int i = 0; i < 8; i++) emitMbf(i, 0, 20 * i + 40, 20 * i + 60, 255);
      emit(32); emit(33); emit(32); emit(34); emit(33); emit(32); emit(33); emit(32);
      emit(48); emit(160);
      emitMbf(7, 0, 128, 128, 255); emit(48); emit(10);
      emit(255);
      runCheck("R7", 64 + n);
    end

    // R9: all truth values zero -> result 0
    loadInput(6, 5);
    wp = 0;
    emitMbf(6, 100, 120, 140, 160); emit(48); emit(77);
    emitMbf(6, 30, 40, 50, 60); emit(48); emit(200);
    emit(255);
    runCheck("R9", 0);
    check("R9", "zero weight result", lastData, 0);

    // R3: unknown opcodes skipped
    loadInput(2, 70);
    wp = 0;
    emit(5); emitMbf(2, 0, 100, 100, 200); emit(64); emit(8'h31);
    emit(48); emit(123); emit(8'hA0);
    emitMbf(2, 60, 80, 80, 90); emit(48); emit(9);
    emit(255);
    runCheck("R3", 33);

    // R2: start while busy ignored and not queued
    progAlpha(2, 0, 100, 100, 200);
    @(negedge clk);
    wrCount = 0; doneCount = 0;
    start = 1'b1; destAddr = 7'd10;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    check("R2", "busy during run", int'(busy), 1);
    start = 1'b1; destAddr = 7'd99;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (doneCount == 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (60) @(negedge clk);
    check("R2", "dest kept", lastAddr, 10);
    check("R2", "single write", wrCount, 1);
    check("R2", "idle after run", int'(busy), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule